// File: doc/BRIEF.md
# Factory Buffered Program Controller

This block is the device-side command logic of a flash array for a production-line programming mode. A host enters the mode with two bus writes: a setup code, then a confirm code. Words then stream in on a fixed start address while an internal pointer fills a 32-word write buffer. A full buffer is committed to a behavioural array model, one location per cycle, followed by a programmable settle delay. The next 32 words continue into the same block without any new setup. A write to any address outside the open block closes the session. Any partly filled buffer is committed first.

While the mode is active, every read returns a status word. The host polls bit 0 before each write, watches bit 7 for the end of the session, and checks bit 4 for errors. Protected blocks are refused at the confirm write, and a misaligned start address is refused at the first data write. Programming is modelled the way flash behaves: each stored word is the bitwise AND of the old contents and the new data, so bits can only clear. The per-block protect bits are loaded through a side port.

Top module: `fbp_ctrl`

## Requirements
- R1: After reset every array word reads all ones, reads return array data, and a write whose low byte is 0x70 switches reads to the status word, which then reads 0x0080.
- R2: A write whose low byte is 0x80 enters setup. Setup clears bit 4, and the status reads 0x0080 while in setup. The next write must have low byte 0xD0; it then opens the mode, and the status reads 0x0000. Any other value sets bit 4 and returns to status mode.
- R3: A confirm aimed at a block whose protect bit is set sets bit 4 and returns to status mode, which reads 0x0090. The block contents stay unchanged.
- R4: A first data write inside the open block whose address is not a multiple of 32 sets bit 4 (status 0x0090) and programs nothing.
- R5: The first data write latches the start address and fills buffer position 0. Each later in-block write fills the next position, whatever address within the block it carries.
- R6: When 32 words have been received, buffer position k is programmed to address start+k, as an AND with the existing contents.
- R7: After a commit, the next 32 in-block writes fill a buffer for the next 32-word region of the same block, with no new setup.
- R8: A write outside the open block ends the session. A partial buffer is committed first, and positions that were not written leave the array unchanged. Bit 0 stays high for 32+PROG_CYC cycles, or ends at once if the buffer is empty. The status then reads 0x0080 (bit 7 set).
- R9: Bit 0 is high for exactly 1 cycle after a word is accepted. After the word that fills the buffer, it is high for 1+32+PROG_CYC cycles. Writes arriving while bit 0 is high are ignored.
- R10: Inside the mode, data words equal to command codes (0x70, 0xFF, 0x80, 0xD0) are stored as data.
- R11: The status word has bit 7 for ready, bit 4 for error and bit 0 for busy; all other bits are zero. Bit 7 is 0 from the confirm until the session ends. A write whose low byte is 0xFF in status mode returns reads to array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bus write strobe, one word per cycle |
| addr_i | input | AW | Word address (block index in the top bits) |
| wdata_i | input | DW | Write data or command code (low byte) |
| rdata_o | output | DW | Array data or status word, combinational |
| prot_we_i | input | 1 | Load one protect bit |
| prot_blk_i | input | BW | Block whose protect bit is loaded |
| prot_val_i | input | 1 | Protect bit value |

## Verification
The bench builds the block with 4 blocks of 64 words, 16-bit data, a 32-word buffer and PROG_CYC of 3. Each block therefore holds exactly two buffers, so a full block exercises both a commit and the continuation into the second region. The whole 256-word array stays small enough to be compared word for word against an AND-model after every session. The short delay keeps the exact busy-cycle counts (1, 35, 36) cheap to measure for every word written.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  typedef enum logic [2:0] {
    ST_ARRAY, ST_STATUS, ST_SETUP, ST_FIRST, ST_FILL, ST_ACK, ST_COMMIT, ST_WAIT
  } fbp_state_e;

  localparam logic [7:0] CMD_SETUP     = 8'h80;
  localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
  localparam logic [7:0] CMD_RD_STATUS = 8'h70;
  localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
endpackage

// File: rtl/fbp_array.sv
module fbp_array #(
  parameter int DW        = 16,
  parameter int NUM_BLKS  = 4,
  parameter int BLK_WORDS = 64,
  localparam int DEPTH    = NUM_BLKS * BLK_WORDS,
  localparam int AW       = $clog2(DEPTH),
  localparam int BW       = $clog2(NUM_BLKS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [AW-1:0]       waddr_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic [AW-1:0]       raddr_i,
  output logic [DW-1:0]       rdata_o,
  input  logic                prot_we_i,
  input  logic [BW-1:0]       prot_blk_i,
  input  logic                prot_val_i,
  output logic [NUM_BLKS-1:0] prot_o
);
  logic [DW-1:0]       mem_q [DEPTH];
  logic [NUM_BLKS-1:0] prot_q;

  // programming can only clear bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < DEPTH; w++) mem_q[w] <= '1;
    end else if (we_i) begin
      mem_q[waddr_i] <= mem_q[waddr_i] & wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        prot_q <= '0;
    else if (prot_we_i) prot_q[prot_blk_i] <= prot_val_i;
  end

  assign rdata_o = mem_q[raddr_i];
  assign prot_o  = prot_q;
endmodule

// File: rtl/fbp_wbuf.sv
module fbp_wbuf #(
  parameter int DW     = 16,
  parameter int DEPTH  = 32,
  localparam int IW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [DW-1:0] dout_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o
);
  logic [CW-1:0]       cnt_q;
  logic [DEPTH*DW-1:0] flat;

  assign full_o = (cnt_q == CW'(DEPTH));

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [DW-1:0] ent_q;
    // unfilled entries stay all ones so they leave the array untouched
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              ent_q <= '1;
      else if (clr_i)                           ent_q <= '1;
      else if (push_i && cnt_q == CW'(g))       ent_q <= din_i;
    end
    assign flat[g*DW +: DW] = ent_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (push_i && !full_o) cnt_q <= cnt_q + 1'b1;
  end

  assign dout_o = flat[rd_idx_i*DW +: DW];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/fbp_ctrl.sv
module fbp_ctrl
  import fbp_pkg::*;
#(
  parameter int DW        = 16,
  parameter int NUM_BLKS  = 4,   // power of two, at least 2
  parameter int BLK_WORDS = 64,  // power of two, at least BUF_WORDS
  parameter int BUF_WORDS = 32,
  parameter int PROG_CYC  = 3,   // settle cycles after each commit, at least 1
  localparam int DEPTH    = NUM_BLKS * BLK_WORDS,
  localparam int AW       = $clog2(DEPTH),
  localparam int BW       = $clog2(NUM_BLKS),
  localparam int OFF_W    = $clog2(BLK_WORDS),
  localparam int IW       = $clog2(BUF_WORDS),
  localparam int CW       = $clog2(BUF_WORDS + 1),
  localparam int PW       = $clog2(PROG_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          prot_we_i,
  input  logic [BW-1:0] prot_blk_i,
  input  logic          prot_val_i
);
  fbp_state_e st_q, st_d;
  logic [BW-1:0]   blk_q, blk_d;
  logic [AW-1:0]   base_q, base_d;
  logic [IW-1:0]   idx_q, idx_d;
  logic [PW-1:0]   wait_q, wait_d;
  logic            err_q, err_d;
  logic            exit_q, exit_d;

  logic            buf_clr, buf_push, buf_full;
  logic [CW-1:0]   buf_cnt;
  logic [DW-1:0]   buf_dout;
  logic            arr_we;
  logic [AW-1:0]   arr_waddr;
  logic [DW-1:0]   arr_rdata;
  logic [NUM_BLKS-1:0] prot;

  logic [BW-1:0]   addr_blk;
  logic [7:0]      cmd;
  logic            in_blk, aligned, ready, busy;
  logic [OFF_W-1:0] next_off;

  assign addr_blk = addr_i[AW-1 -: BW];
  assign cmd      = wdata_i[7:0];
  assign in_blk   = (addr_blk == blk_q);
  assign aligned  = (addr_i[IW-1:0] == '0);
  assign next_off = base_q[OFF_W-1:0] + OFF_W'(BUF_WORDS);

  assign arr_we    = (st_q == ST_COMMIT);
  assign arr_waddr = {base_q[AW-1:IW], idx_q};

  fbp_wbuf #(.DW(DW), .DEPTH(BUF_WORDS)) i_wbuf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (buf_clr),
    .push_i   (buf_push),
    .din_i    (wdata_i),
    .rd_idx_i (idx_q),
    .dout_o   (buf_dout),
    .cnt_o    (buf_cnt),
    .full_o   (buf_full)
  );

  fbp_array #(.DW(DW), .NUM_BLKS(NUM_BLKS), .BLK_WORDS(BLK_WORDS)) i_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (arr_we),
    .waddr_i    (arr_waddr),
    .wdata_i    (buf_dout),
    .raddr_i    (addr_i),
    .rdata_o    (arr_rdata),
    .prot_we_i  (prot_we_i),
    .prot_blk_i (prot_blk_i),
    .prot_val_i (prot_val_i),
    .prot_o     (prot)
  );

  always_comb begin
    st_d     = st_q;
    blk_d    = blk_q;
    base_d   = base_q;
    idx_d    = idx_q;
    wait_d   = wait_q;
    err_d    = err_q;
    exit_d   = exit_q;
    buf_clr  = 1'b0;
    buf_push = 1'b0;
    unique case (st_q)
      ST_ARRAY, ST_STATUS: if (wr_en_i) begin
        if (cmd == CMD_SETUP) begin
          st_d  = ST_SETUP;
          err_d = 1'b0;
        end else if (cmd == CMD_RD_STATUS) st_d = ST_STATUS;
        else if (cmd == CMD_RD_ARRAY)      st_d = ST_ARRAY;
      end
      ST_SETUP: if (wr_en_i) begin
        if (cmd == CMD_CONFIRM && !prot[addr_blk]) begin
          st_d    = ST_FIRST;
          blk_d   = addr_blk;
          buf_clr = 1'b1;
        end else begin
          st_d  = ST_STATUS;
          err_d = 1'b1;
        end
      end
      ST_FIRST: if (wr_en_i) begin
        if (!in_blk) st_d = ST_STATUS;
        else if (!aligned) begin
          st_d  = ST_STATUS;
          err_d = 1'b1;
        end else begin
          base_d   = addr_i;
          buf_push = 1'b1;
          st_d     = ST_ACK;
        end
      end
      ST_FILL: if (wr_en_i) begin
        if (!in_blk) begin
          if (buf_cnt == '0) st_d = ST_STATUS;
          else begin
            exit_d = 1'b1;
            idx_d  = '0;
            st_d   = ST_COMMIT;
          end
        end else begin
          buf_push = 1'b1;
          st_d     = ST_ACK;
        end
      end
      ST_ACK: begin
        if (buf_full) begin
          idx_d = '0;
          st_d  = ST_COMMIT;
        end else st_d = ST_FILL;
      end
      ST_COMMIT: begin
        if (idx_q == IW'(BUF_WORDS - 1)) begin
          wait_d = '0;
          st_d   = ST_WAIT;
        end else idx_d = idx_q + 1'b1;
      end
      ST_WAIT: begin
        if (wait_q == PW'(PROG_CYC - 1)) begin
          buf_clr = 1'b1;
          base_d  = {blk_q, next_off};
          exit_d  = 1'b0;
          st_d    = exit_q ? ST_STATUS : ST_FILL;
        end else wait_d = wait_q + 1'b1;
      end
      default: st_d = ST_ARRAY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_ARRAY;
      blk_q  <= '0;
      base_q <= '0;
      idx_q  <= '0;
      wait_q <= '0;
      err_q  <= 1'b0;
      exit_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      blk_q  <= blk_d;
      base_q <= base_d;
      idx_q  <= idx_d;
      wait_q <= wait_d;
      err_q  <= err_d;
      exit_q <= exit_d;
    end
  end

  assign ready = (st_q == ST_ARRAY) || (st_q == ST_STATUS) || (st_q == ST_SETUP);
  assign busy  = (st_q == ST_ACK) || (st_q == ST_COMMIT) || (st_q == ST_WAIT);

  always_comb begin
    if (st_q == ST_ARRAY) rdata_o = arr_rdata;
    else                  rdata_o = DW'({ready, 2'b00, err_q, 3'b000, busy});
  end
endmodule

// File: rtl/fbp_ctrl_chk.sv
module fbp_ctrl_chk
  import fbp_pkg::*;
#(
  parameter int DW        = 16,
  parameter int AW        = 8,
  parameter int BW        = 2,
  parameter int CW        = 6,
  parameter int NUM_BLKS  = 4,
  parameter int BUF_WORDS = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input fbp_state_e          st_q,
  input logic                arr_we,
  input logic [AW-1:0]       arr_waddr,
  input logic [BW-1:0]       blk_q,
  input logic [NUM_BLKS-1:0] prot,
  input logic [CW-1:0]       buf_cnt,
  input logic [DW-1:0]       rdata_o,
  input logic                err_q
);
  a_r3_no_write_protected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we |-> !prot[arr_waddr[AW-1 -: BW]]);

  a_r6_commit_in_blk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we |-> arr_waddr[AW-1 -: BW] == blk_q);

  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_cnt <= CW'(BUF_WORDS));

  a_r9_busy_no_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_COMMIT || st_q == ST_WAIT) |=> (buf_cnt == $past(buf_cnt) || buf_cnt == '0));

  a_r11_not_ready_in_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FIRST || st_q == ST_FILL || st_q == ST_ACK || st_q == ST_COMMIT || st_q == ST_WAIT)
      |-> !rdata_o[7]);

  a_r2_err_to_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> st_q == ST_STATUS);

  a_r8_commit_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_COMMIT) |=> (st_q == ST_COMMIT || st_q == ST_WAIT));
endmodule

bind fbp_ctrl fbp_ctrl_chk #(
  .DW(DW), .AW(AW), .BW(BW), .CW(CW), .NUM_BLKS(NUM_BLKS), .BUF_WORDS(BUF_WORDS)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .st_q      (st_q),
  .arr_we    (arr_we),
  .arr_waddr (arr_waddr),
  .blk_q     (blk_q),
  .prot      (prot),
  .buf_cnt   (buf_cnt),
  .rdata_o   (rdata_o),
  .err_q     (err_q)
);

// File: tb/test_fbp_ctrl.sv
module test_fbp_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 16;
  localparam int NB    = 4;
  localparam int BLKW  = 64;
  localparam int BUFW  = 32;
  localparam int PC    = 3;
  localparam int DEPTH = NB * BLKW;
  localparam int AW    = 8;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic prot_we = 1'b0, prot_val = 1'b0;
  logic [1:0] prot_blk = '0;

  int total = 0, bad = 0;
  logic [DW-1:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  fbp_ctrl #(.DW(DW), .NUM_BLKS(NB), .BLK_WORDS(BLKW), .BUF_WORDS(BUFW), .PROG_CYC(PC)) i_fbp_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .prot_we_i(prot_we), .prot_blk_i(prot_blk), .prot_val_i(prot_val)
  );

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (rdata[0] && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic check_array(string tag);
    wr('0, 16'h00FF);
    for (int a = 0; a < DEPTH; a++) begin
      addr = AW'(a);
      #1;
      check(tag, rdata, model[a]);
    end
    wr('0, 16'h0070);
  endtask

  function automatic logic [DW-1:0] pat(int b, int i);
    case (i)
      3: return 16'h0070;
      4: return 16'h00FF;
      5: return 16'h0080;
      6: return 16'h00D0;
      default: return DW'((b * 16'h1111) ^ (i * 16'h0241) ^ 16'hA5C3);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    for (int a = 0; a < DEPTH; a++) model[a] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    addr = 8'd5; #1;
    check("R1 array erased", rdata, 16'hFFFF);
    wr('0, 16'h0070);
    check("R1 status after reset", rdata, 16'h0080);

    // R5 R6 R7 R9 R10: full two-buffer sessions on every block
    for (int b = 0; b < NB; b++) begin
      logic [AW-1:0] sa;
      sa = AW'(b * BLKW);
      wr(sa, 16'h0080);
      check("R2 setup status", rdata, 16'h0080);
      wr(sa, 16'h00D0);
      check("R2 R11 confirmed status", rdata, 16'h0000);
      for (int i = 0; i < BLKW; i++) begin
        logic [DW-1:0] d;
        d = pat(b, i);
        wr(sa, d);
        model[b*BLKW + i] = model[b*BLKW + i] & d;
        wait_busy(n);
        check("R9 busy cycles", DW'(n), DW'(((i % BUFW) == BUFW-1) ? 1 + BUFW + PC : 1));
        if (i == BUFW-1) check("R7 R11 mode after commit", rdata, 16'h0000);
      end
      wr(AW'(((b + 1) % NB) * BLKW), 16'h5555);
      wait_busy(n);
      check("R8 empty exit immediate", DW'(n), 16'd0);
      check("R8 exit status", rdata, 16'h0080);
      check_array("R6 R10 array after session");
    end

    // R8 partial buffer, AND semantics
    wr(8'd0, 16'h0080);
    wr(8'd0, 16'h00D0);
    for (int i = 0; i < 10; i++) begin
      wr(8'd0, 16'hF0F0 ^ DW'(i));
      model[i] = model[i] & (16'hF0F0 ^ DW'(i));
      wait_busy(n);
    end
    wr(8'd200, 16'h1111);
    wait_busy(n);
    check("R8 partial commit busy", DW'(n), DW'(BUFW + PC));
    check("R8 partial exit status", rdata, 16'h0080);
    check_array("R8 R6 partial AND");

    // R3 protected block
    @(negedge clk);
    prot_we = 1'b1; prot_blk = 2'd2; prot_val = 1'b1;
    @(negedge clk);
    prot_we = 1'b0;
    wr(8'd128, 16'h0080);
    wr(8'd128, 16'h00D0);
    check("R3 protected abort", rdata, 16'h0090);
    wr(8'd128, 16'h0000);
    check_array("R3 protected unchanged");

    // R2 bad confirm, R11 setup clears error
    wr(8'd64, 16'h0080);
    wr(8'd64, 16'h0012);
    check("R2 bad confirm", rdata, 16'h0090);
    wr(8'd64, 16'h0080);
    check("R11 setup clears error", rdata, 16'h0080);
    wr(8'd64, 16'h00D0);
    check("R2 confirm ok", rdata, 16'h0000);
    // R4 misaligned start
    wr(8'd67, 16'h0000);
    check("R4 misaligned", rdata, 16'h0090);
    check_array("R4 no program");

    // R9 write during busy is ignored
    wr(8'd192, 16'h0080);
    wr(8'd192, 16'h00D0);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'd192; wdata = 16'h0F0F;
    @(negedge clk);
    check("R9 busy after accept", rdata, 16'h0001);
    wdata = 16'h0000;
    @(negedge clk);
    wr_en = 1'b0;
    wait_busy(n);
    wr(8'd192, 16'hFFF0);
    wait_busy(n);
    wr(8'd0, 16'h2222);
    wait_busy(n);
    model[192] = model[192] & 16'h0F0F;
    model[193] = model[193] & 16'hFFF0;
    check_array("R9 busy write ignored");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule